// File: doc/BRIEF.md
# Bus Read Handshake Bridge

This block is a clocked controller that links a processor-side read handshake to a device-side handshake. The bus side raises a read strobe and waits for an acknowledge. The controller then runs a strobe/acknowledge exchange with the local device, enables the data transceiver, and acknowledges the bus. Both asynchronous inputs are passed through two-flop synchronizers. The outputs then change in one fixed partial order, and no more than one output changes on any clock edge.

The return-to-zero phase has two branches that overlap: the bus acknowledge falls, and the local strobe/acknowledge pair resets. One internal phase bit is needed because the same pin code, with strobe, local strobe and local acknowledge high and the other two low, occurs at two points in a cycle. After the local acknowledge rises, the transceiver must be enabled next. On a later return, the local strobe must drop next. The phase bit is 1 in the first case and 0 in the second.

Top module: `hs_read_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, `bus_ack`, `dev_strobe`, `xcvr_en` and the internal phase bit are 0 after that edge.
- R2: `bus_strobe` and `dev_ack` are used only after two synchronizer flops. When `bus_strobe` rises in idle, the phase bit sets on the third clock edge and `dev_strobe` rises on the fourth.
- R3: The rising order is `dev_strobe`, then `xcvr_en`, then `bus_ack`. `xcvr_en` rises on the third edge after `dev_ack` rises, and `bus_ack` rises on the next edge. The environment may drop `bus_strobe` only after `bus_ack` is high, and may move `dev_ack` only to follow `dev_strobe`.
- R4: After `bus_strobe` falls, `xcvr_en` falls on the third edge, the phase bit clears on the fourth, and `bus_ack` falls on the fifth.
- R5: At most one of `bus_ack`, `dev_strobe`, `xcvr_en` changes on any clock edge.
- R6: `dev_strobe` rises for a new cycle only when the synchronized `dev_ack` is low and `bus_ack` is low. If `dev_ack` stays high, `dev_strobe` stays low. It rises on the fourth edge after `dev_ack` falls.
- R7: When both branches of the return are enabled, `bus_ack` falls first and `dev_strobe` falls on the next edge. With the phase bit at 1, a high `dev_ack` enables `xcvr_en`. With the phase bit at 0, it lets `dev_strobe` fall.
- R8: In idle with `bus_strobe` low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_strobe | input | 1 | Bus read strobe, asynchronous |
| dev_ack | input | 1 | Local device acknowledge, asynchronous |
| bus_ack | output | 1 | Acknowledge to the bus |
| dev_strobe | output | 1 | Strobe to the local device |
| xcvr_en | output | 1 | Data transceiver enable |

## Verification
Two events can become due in the same cycle: the bus acknowledge falling and the local strobe falling. Both are enabled once the transceiver is off and the phase bit has cleared. The bench provokes this on every read cycle by dropping the bus strobe while the local acknowledge is still high. The scoreboard expects `bus_ack` to fall exactly five edges after the strobe drop and `dev_strobe` to fall on the next edge. A single edge that changes both outputs is reported as a failure.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef struct packed {
        logic ack;     // bus acknowledge
        logic strobe;  // device strobe
        logic xcvr;    // transceiver enable
        logic phase;   // separates the two uses of the shared pin code
    } hs_state_t;

    localparam hs_state_t HS_IDLE = '{ack: 1'b0, strobe: 1'b0, xcvr: 1'b0, phase: 1'b0};
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hs_ctrl_core.sv
module hs_ctrl_core
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe_s,
    input  logic      dack_s,
    output hs_state_t state_o
);
    hs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.phase && !st_q.ack && !st_q.strobe && !st_q.xcvr && strobe_s && !dack_s)
            st_d.phase = 1'b1;                       // open a new cycle
        else if (st_q.phase && !st_q.strobe && !st_q.xcvr && !st_q.ack && strobe_s && !dack_s)
            st_d.strobe = 1'b1;                      // request the device
        else if (st_q.phase && st_q.strobe && dack_s && !st_q.xcvr && !st_q.ack && strobe_s)
            st_d.xcvr = 1'b1;                        // device answered: enable data
        else if (st_q.xcvr && !st_q.ack)
            st_d.ack = 1'b1;                         // acknowledge the bus
        else if (st_q.xcvr && st_q.ack && !strobe_s)
            st_d.xcvr = 1'b0;                        // bus released
        else if (st_q.phase && st_q.ack && !st_q.xcvr && !strobe_s)
            st_d.phase = 1'b0;                       // enter return phase
        else if (!st_q.phase && st_q.ack && !strobe_s)
            st_d.ack = 1'b0;                         // bus branch first
        else if (!st_q.phase && st_q.strobe && dack_s && !st_q.xcvr)
            st_d.strobe = 1'b0;                      // device branch
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= HS_IDLE;
        else     st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/hs_read_bridge.sv
module hs_read_bridge
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_strobe,
    input  logic dev_ack,
    output logic bus_ack,
    output logic dev_strobe,
    output logic xcvr_en
);
    localparam int NUM_ASYNC = 2;

    logic [NUM_ASYNC-1:0] raw_in, sync_out;
    logic                 strobe_sync, dack_sync, phase;
    hs_state_t            state;

    assign raw_in = {dev_ack, bus_strobe};

    hs_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_in),
        .dout(sync_out)
    );

    assign strobe_sync = sync_out[0];
    assign dack_sync   = sync_out[1];

    hs_ctrl_core i_core (
        .clk     (clk),
        .rst     (rst),
        .strobe_s(strobe_sync),
        .dack_s  (dack_sync),
        .state_o (state)
    );

    assign bus_ack    = state.ack;
    assign dev_strobe = state.strobe;
    assign xcvr_en    = state.xcvr;
    assign phase      = state.phase;
endmodule

// File: rtl/hs_read_bridge_chk.sv
module hs_read_bridge_chk (
    input logic clk,
    input logic rst,
    input logic strobe_sync,
    input logic dack_sync,
    input logic phase,
    input logic bus_ack,
    input logic dev_strobe,
    input logic xcvr_en
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!bus_ack && !dev_strobe && !xcvr_en && !phase));

    p_one_change_r5: assert property (@(posedge clk) disable iff (rst)
        $countones({bus_ack, dev_strobe, xcvr_en} ^ $past({bus_ack, dev_strobe, xcvr_en})) <= 1);

    p_xcvr_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(xcvr_en) |-> (dev_strobe && phase && dack_sync));

    p_ack_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> xcvr_en);

    p_env_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_sync) |-> bus_ack);

    p_env_dack_up_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dack_sync) |-> dev_strobe);

    p_env_dack_dn_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(dack_sync) |-> !dev_strobe);

    p_ack_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ack) |-> (!xcvr_en && !phase && !strobe_sync));

    p_strobe_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_strobe) |-> (!dack_sync && !bus_ack && phase));

    p_strobe_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_strobe) |-> (!phase && !xcvr_en && !bus_ack));
endmodule

bind hs_read_bridge hs_read_bridge_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_sync(strobe_sync),
    .dack_sync  (dack_sync),
    .phase      (phase),
    .bus_ack    (bus_ack),
    .dev_strobe (dev_strobe),
    .xcvr_en    (xcvr_en)
);

// File: tb/test_hs_read_bridge.sv
module test_hs_read_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0, rst = 1'b1, bus_strobe = 1'b0, dev_ack = 1'b0;
    logic bus_ack, dev_strobe, xcvr_en;

    hs_read_bridge i_hs_read_bridge (
        .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .dev_ack(dev_ack),
        .bus_ack(bus_ack), .dev_strobe(dev_strobe), .xcvr_en(xcvr_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [2:0] vec;   // {bus_ack, dev_strobe, xcvr_en}
        int         due;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         cyc = 0, checks = 0, fails = 0;
    logic [2:0] prev_vec = 3'b000;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input logic [2:0] v, input int due, input string tag);
        exp_t e;
        e.vec = v; e.due = due; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: every output change must match the head of the scoreboard
    always @(negedge clk) begin
        logic [2:0] cur;
        cur = {bus_ack, dev_strobe, xcvr_en};
        if (!rst && cur != prev_vec) begin
            check($countones(cur ^ prev_vec) <= 1, "R5 one change per edge",
                  $countones(cur ^ prev_vec), 1);
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected output change", int'(cur), int'(prev_vec));
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(cur == e.vec, {e.tag, " value"}, int'(cur), int'(e.vec));
                check(cyc == e.due, {e.tag, " cycle"}, cyc, e.due);
            end
        end
        prev_vec = cur;
    end

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe_up();
        @(negedge clk); bus_strobe = 1'b1;
        push(3'b010, cyc + 4, "R2 dev_strobe rise");
        drain();
    endtask

    task automatic dack_up(input int delay);
        repeat (delay) @(negedge clk);
        @(negedge clk); dev_ack = 1'b1;
        push(3'b011, cyc + 3, "R3 R7 xcvr_en rise");
        push(3'b111, cyc + 4, "R3 bus_ack rise");
        drain();
    endtask

    task automatic strobe_down();
        @(negedge clk); bus_strobe = 1'b0;
        push(3'b110, cyc + 3, "R4 xcvr_en fall");
        push(3'b010, cyc + 5, "R4 bus_ack fall first");
        push(3'b000, cyc + 6, "R7 dev_strobe fall next");
        drain();
    endtask

    task automatic dack_down();
        @(negedge clk); dev_ack = 1'b0;
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({bus_ack, dev_strobe, xcvr_en} == 3'b000, "R1 reset outputs",
              int'({bus_ack, dev_strobe, xcvr_en}), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check({bus_ack, dev_strobe, xcvr_en} == 3'b000, "R8 idle quiet",
              int'({bus_ack, dev_strobe, xcvr_en}), 0);

        // plain cycle, fast device
        strobe_up(); dack_up(0); strobe_down(); dack_down();
        // slow device
        strobe_up(); dack_up(6); strobe_down(); dack_down();
        // device holds its acknowledge while the bus starts the next cycle
        strobe_up(); dack_up(1); strobe_down();
        @(negedge clk); bus_strobe = 1'b1;
        repeat (12) @(negedge clk);
        check(dev_strobe == 1'b0, "R6 dev_strobe held while dev_ack high", dev_strobe, 0);
        @(negedge clk); dev_ack = 1'b0;
        push(3'b010, cyc + 4, "R6 dev_strobe rise after dev_ack low");
        drain();
        dack_up(2); strobe_down(); dack_down();

        // reset in the middle of a cycle
        strobe_up(); dack_up(0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check({bus_ack, dev_strobe, xcvr_en} == 3'b000, "R1 mid-cycle reset",
              int'({bus_ack, dev_strobe, xcvr_en}), 0);
        bus_strobe = 1'b0; dev_ack = 1'b0;
        repeat (4) @(negedge clk);
        prev_vec = 3'b000;
        rst = 1'b0;
        repeat (10) @(negedge clk);
        strobe_up(); dack_up(3); strobe_down(); dack_down();

        check(sb_q.size() == 0, "R5 scoreboard empty", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule